// File: doc/BRIEF.md
# Per-CPU Interval Ignore Counter

This block takes one shared periodic timer line and decides, separately for each of four processors, whether a given timer tick becomes a timer event for that processor. Each processor owns a down-counter. Every rising edge of the timer line decrements all four counters by one. A counter that has passed below zero raises a sticky overflow flag. From that tick on, every further tick produces a one-cycle event pulse for that processor.

Software loads a counter with the number of ticks to skip. It can later read the counter back. The count keeps falling after the overflow, so the value read shows how many ticks arrived since delivery started. The timer line is asynchronous and passes through a two-flop synchronizer before the edge detector. The register port is a simple single-cycle write strobe with a combinational read.

Top module: `interval_skip_counter`

## Requirements
- R1: After reset every counter reads as zero with its overflow flag clear, and no event pulse is asserted.
- R2: The counters for processors 0, 1, 2 and 3 are reached at address 0x380, 0x3C0, 0x700 and 0x740 respectively. Any other address reads as zero, and a write to any other address changes no counter.
- R3: A write loads bits [CNT_W-1:0] of the write data into the count field and clears the overflow flag. Data bits above the count field are ignored. A read returns the count in bits [CNT_W-1:0], the overflow flag in bit CNT_W (bit 24 by default) and zeros above it.
- R4: Each tick replaces every counter's (CNT_W+1)-bit value v with ((v - 1) mod 2^(CNT_W+1)), and then ORs the old overflow flag back into bit CNT_W. Without a tick, the value holds.
- R5: Once set, the overflow flag stays set through any number of ticks until that counter is written.
- R6: On each tick, a processor's event bit pulses high for exactly one cycle when its counter's overflow flag is set after that tick's decrement. Otherwise the bit stays low.
- R7: Only a rising edge of tick_in is a tick. Holding tick_in high or letting it fall does not decrement any counter and produces no event.
- R8: When a write reaches a counter in the same cycle as a tick, the write wins. That counter takes the written value and emits no event for the tick, while the other counters decrement normally.
- R9: The event pulse is asserted in the third clock cycle after tick_in rises: two synchronizer stages, then the counter update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Asynchronous shared periodic timer line |
| csr_we | input | 1 | Register write strobe, one cycle per write |
| csr_addr | input | 12 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for csr_addr (combinational) |
| timer_evt | output | 4 | Per-processor timer event pulses, bit i for processor i |

## Verification
The bench builds the block with CNT_W = 4, so the overflow flag sits at bit 4 and a counter's value space has only 32 states. With this width, every counter can be walked through the full wrap, from every loaded value through underflow and on around the sticky range, within a few hundred ticks. Each processor starts from a different value, so the four event lines assert at different ticks and a swapped or shared lane shows up. The bench also drives collisions between writes and ticks, long high and low levels on the timer line, and writes to unmapped addresses.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;

    typedef logic [ADDR_W-1:0] csr_addr_t;
    typedef logic [DATA_W-1:0] csr_data_t;

    typedef struct packed {
        logic      we;
        csr_addr_t addr;
        csr_data_t wdata;
    } csr_req_t;

    typedef enum logic [1:0] {
        SLOT_CPU0 = 2'd0,
        SLOT_CPU1 = 2'd1,
        SLOT_CPU2 = 2'd2,
        SLOT_CPU3 = 2'd3
    } slot_id_t;

    // Byte offset at which each processor's counter is decoded.
    function automatic csr_addr_t slot_offset(input slot_id_t id);
        case (id)
            SLOT_CPU0: slot_offset = 12'h380;
            SLOT_CPU1: slot_offset = 12'h3C0;
            SLOT_CPU2: slot_offset = 12'h700;
            default:   slot_offset = 12'h740;
        endcase
    endfunction

endpackage

// File: rtl/isc_tick_detect.sv
module isc_tick_detect (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic tick_pulse
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= tick_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign tick_pulse = sync_q & ~prev_q;

    // R7: a tick lasts exactly one cycle, however long the line stays high
    a_r7_single_tick: assert property (@(posedge clk) disable iff (rst)
        tick_pulse |=> !tick_pulse);

endmodule

// File: rtl/isc_slot.sv
module isc_slot #(
    parameter int CNT_W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W:0]   value,
    output logic         evt
);
    localparam int VAL_W = CNT_W + 1;

    typedef struct packed {
        logic             ovf;
        logic [CNT_W-1:0] cnt;
    } slot_val_t;

    slot_val_t  cur_q;
    slot_val_t  dec_val;
    logic [VAL_W-1:0] minus_one;
    logic       evt_q;

    always_comb begin
        minus_one   = cur_q - 1'b1;
        dec_val.cnt = minus_one[CNT_W-1:0];
        dec_val.ovf = minus_one[CNT_W] | cur_q.ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (load_en) begin
                cur_q.cnt <= load_val;
                cur_q.ovf <= 1'b0;
            end else if (tick) begin
                cur_q <= dec_val;
                evt_q <= dec_val.ovf;
            end
        end
    end

    assign value = cur_q;
    assign evt   = evt_q;

    // R5: overflow persists until a write
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (cur_q.ovf && !load_en) |=> cur_q.ovf);
    // R3: a write lands its count and clears the flag
    a_r3_write_loads: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (value == {1'b0, $past(load_val)}));
    // R8: a write colliding with a tick suppresses the event
    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        (load_en && tick) |=> !evt);
    // R6: no event without the flag
    a_r6_evt_needs_ovf: assert property (@(posedge clk) disable iff (rst)
        evt |-> cur_q.ovf);
    // R4: idle cycles leave the counter alone
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !tick) |=> $stable(value));

endmodule

// File: rtl/isc_csr_decode.sv
module isc_csr_decode
    import isc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  csr_req_t                           req,
    input  logic [NUM_SLOTS-1:0][CNT_W:0]      slot_val,
    output logic [NUM_SLOTS-1:0]               slot_hit,
    output logic [NUM_SLOTS-1:0]               slot_wr,
    output logic [CNT_W-1:0]                   load_val,
    output csr_data_t                          rdata
);
    localparam int PAD_W = DATA_W - CNT_W - 1;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
        assign slot_hit[i] = (req.addr == slot_offset(slot_id_t'(i)));
        assign slot_wr[i]  = req.we & slot_hit[i];
    end

    assign load_val = req.wdata[CNT_W-1:0];

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_hit[i]) begin
                rdata = {{PAD_W{1'b0}}, slot_val[i]};
            end
        end
    end

endmodule

// File: rtl/interval_skip_counter.sv
module interval_skip_counter
    import isc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_in,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic [3:0]  timer_evt
);
    csr_req_t                      req;
    logic                          tick_pulse;
    logic [NUM_SLOTS-1:0]          slot_hit;
    logic [NUM_SLOTS-1:0]          slot_wr;
    logic [CNT_W-1:0]              load_val;
    logic [NUM_SLOTS-1:0][CNT_W:0] slot_val;
    logic [NUM_SLOTS-1:0]          slot_evt;

    assign req.we    = csr_we;
    assign req.addr  = csr_addr;
    assign req.wdata = csr_wdata;

    isc_tick_detect u_tick (
        .clk        (clk),
        .rst        (rst),
        .tick_in    (tick_in),
        .tick_pulse (tick_pulse)
    );

    isc_csr_decode #(.CNT_W(CNT_W)) u_dec (
        .req      (req),
        .slot_val (slot_val),
        .slot_hit (slot_hit),
        .slot_wr  (slot_wr),
        .load_val (load_val),
        .rdata    (csr_rdata)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        isc_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_pulse),
            .load_en  (slot_wr[i]),
            .load_val (load_val),
            .value    (slot_val[i]),
            .evt      (slot_evt[i])
        );
    end

    assign timer_evt = slot_evt;

    // R2: at most one counter decoded per access
    a_r2_one_slot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_hit));
    // R6: events only follow a tick
    a_r6_evt_after_tick: assert property (@(posedge clk) disable iff (rst)
        (timer_evt != 4'b0) |-> $past(tick_pulse));
    // R1: quiet out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (timer_evt == 4'b0));

endmodule

// File: tb/interval_skip_counter_test.sv
module interval_skip_counter_test;
    localparam int CW   = 4;
    localparam int VW   = CW + 1;
    localparam int MOD  = 1 << VW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_in = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [3:0]  timer_evt;

    int n_checks = 0;
    int n_fail   = 0;
    int model [4];
    logic [11:0] offs [4] = '{12'h380, 12'h3C0, 12'h700, 12'h740};

    always #4 clk = ~clk;

    interval_skip_counter #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .tick_in(tick_in), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .timer_evt(timer_evt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int dec_model(input int v);
        int ovf = v & (1 << CW);
        return ((v - 1 + MOD) % MOD) | ovf;
    endfunction

    task automatic read_all(input string req);
        for (int i = 0; i < 4; i++) begin
            csr_addr = offs[i];
            #1;
            check(req, csr_rdata, model[i]);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
        for (int i = 0; i < 4; i++)
            if (offs[i] == a) model[i] = d & ((1 << CW) - 1);
    endtask

    // One tick with full event and latency check (R4, R6, R9)
    task automatic do_tick;
        logic [3:0] exp_evt;
        @(negedge clk); tick_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 early", timer_evt, 4'b0);
        @(posedge clk); @(negedge clk);
        exp_evt = '0;
        for (int i = 0; i < 4; i++) begin
            model[i] = dec_model(model[i]);
            exp_evt[i] = (model[i] >> CW) & 1;
        end
        check("R6", timer_evt, exp_evt);
        @(negedge clk);
        check("R6 one cycle", timer_evt, 4'b0);
        tick_in = 1'b0;
        repeat (3) @(negedge clk);
        read_all("R4");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) model[i] = 0;
        // R1 reset state
        check("R1 evt", timer_evt, 4'b0);
        read_all("R1");

        // R2 / R3: each slot loads, upper bits ignored, unmapped addresses inert
        for (int i = 0; i < 4; i++) wr(offs[i], 32'hFFFF_FFF0 | (i * 3 + 2));
        read_all("R3");
        wr(12'h384, 32'h0000_000F);
        wr(12'h000, 32'h0000_0007);
        read_all("R2 unmapped write");
        csr_addr = 12'h384; #1;
        check("R2 unmapped read", csr_rdata, 32'h0);

        // Exhaustive walk through the wrap, distinct start per lane (R4, R5, R6)
        wr(offs[0], 0); wr(offs[1], 3); wr(offs[2], 9); wr(offs[3], 15);
        for (int t = 0; t < 40; t++) do_tick();
        check("R5 sticky", model[3] >> CW, 1);

        // Sweep every load value on lane 2 to its underflow tick
        for (int v = 0; v < (1 << CW); v++) begin
            wr(offs[2], v);
            for (int t = 0; t <= v; t++) do_tick();
        end

        // R7: held level and falling edge do nothing
        wr(offs[1], 6);
        @(negedge clk); tick_in = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) model[i] = dec_model(model[i]);
        repeat (12) @(negedge clk);
        check("R7 held high", timer_evt, 4'b0);
        read_all("R7 held high");
        tick_in = 1'b0;
        repeat (8) @(negedge clk);
        check("R7 falling", timer_evt, 4'b0);
        read_all("R7 falling");

        // R8: write colliding with tick on lane 0 (overflowed) wins
        for (int k = 0; k < 4; k++) begin
            logic [3:0] exp_evt;
            @(negedge clk); tick_in = 1'b1;
            @(posedge clk); @(posedge clk); @(negedge clk);
            csr_we = 1'b1; csr_addr = offs[k]; csr_wdata = 32'h5;
            @(posedge clk); @(negedge clk);
            csr_we = 1'b0;
            exp_evt = '0;
            for (int i = 0; i < 4; i++) begin
                if (i == k) model[i] = 5;
                else begin
                    model[i] = dec_model(model[i]);
                    exp_evt[i] = (model[i] >> CW) & 1;
                end
            end
            check("R8 evt", timer_evt, exp_evt);
            tick_in = 1'b0;
            repeat (4) @(negedge clk);
            read_all("R8");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule